// File: doc/BRIEF.md
# Debug Console Packet Framer

This block sits between a payload buffer and a serial transmitter on the debug side of a chip. Software or a controller first writes up to `MAX_LEN` payload bytes into the block's internal buffer, then requests a send with a length. In framed mode the block sends a checksummed console-output packet, one byte at a time, over a valid/ready byte stream. Every payload byte becomes two lowercase hex characters. When the packet is out, the block listens on the received byte stream for a one-byte acknowledge. If that byte is not a plus sign, it sends the whole packet again.

In raw mode the buffer is sent unchanged, except that a carriage return goes out before every line feed. There is no acknowledge phase in raw mode. In both modes a one-cycle `done` pulse marks the end of the job.

Top module: `dbg_pkt_framer`

## Requirements
- R1: A framed packet is the byte sequence 0x24 ('$'), 0x4F ('O'), then two hex characters for each payload byte in buffer order with the high nibble first, then 0x23 ('#'), then two checksum hex characters with the high nibble first.
- R2: A hex character for nibble value v is 0x30+v for v below 10 and 0x61+(v-10) otherwise, so the letters are lowercase.
- R3: The checksum starts at 0x4F. Each payload hex character that is sent is added to it modulo 256. The final 8-bit value is the one that is sent.
- R4: A framed send with length zero emits exactly `$O#4f`.
- R5: Once the last checksum character is accepted, the block holds `outValid` low. It then waits for a received byte, and a 0x2B ('+') ends the job.
- R6: If the byte received while waiting is anything other than 0x2B, the block resends the complete packet starting from 0x24.
- R7: The output byte changes only on a cycle where `outValid` and `outReady` are both high. While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays the same.
- R8: Received bytes that arrive before the last checksum character has been accepted have no effect. Such a byte neither ends nor restarts the packet.
- R9: In raw mode (`rawMode`=1 at start) each payload byte is sent unchanged. Every 0x0A is sent as 0x0D followed by 0x0A.
- R10: `done` is high for exactly one cycle. It rises after an acknowledge is received in framed mode, or after the last raw byte is accepted in raw mode.
- R11: A start request made while a job is in progress is ignored. Lengths above `MAX_LEN` are clamped to `MAX_LEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loadWe | input | 1 | Write strobe for the payload buffer |
| loadAddr | input | 6 | Payload buffer write address |
| loadData | input | 8 | Payload byte to write |
| payLen | input | 7 | Number of payload bytes to send, sampled at start |
| rawMode | input | 1 | 1 selects raw mode, sampled at start |
| startReq | input | 1 | Start a job (taken only when idle) |
| outData | output | 8 | Byte offered to the transmitter |
| outValid | output | 1 | outData is valid |
| outReady | input | 1 | Transmitter accepts the byte |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | rxData is valid this cycle |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench drives `outReady` at random, so a design that advances or changes its byte while stalled puts the packet out of order against the scoreboard. A zero-length packet and a full 64-byte packet both exercise the checksum. A design that seeds or wraps the checksum wrongly, or that emits hex for an empty buffer, sends the wrong tail. A negative acknowledge must cause a complete resend; a design that resumes mid-packet or gives up leaves expected bytes unsent. A '+' injected mid-packet and a start request made while busy must both be harmless; a design that honours either one ends early or switches mode. In raw mode, a design that drops the inserted carriage return or inserts it twice fails the byte comparison.

// File: rtl/dbg_frm_pkg.sv
package dbg_frm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DOLLAR, ST_TAG, ST_HI, ST_LO, ST_HASH, ST_CKHI, ST_CKLO, ST_WAIT, ST_RAW
  } state_t;

  typedef enum logic [2:0] {
    SEL_DOLLAR, SEL_TAG, SEL_HI, SEL_LO, SEL_HASH, SEL_CKHI, SEL_CKLO, SEL_RAW
  } sel_t;

  typedef struct packed {
    logic lenLoad;
    logic idxClr;
    logic idxInc;
    logic sumInit;
    logic sumAdd;
    logic crSet;
    logic crClr;
    sel_t sel;
  } strobe_t;

  localparam logic [7:0] CH_DOLLAR = 8'h24;
  localparam logic [7:0] CH_TAG    = 8'h4F;
  localparam logic [7:0] CH_HASH   = 8'h23;
  localparam logic [7:0] CH_ACK    = 8'h2B;
  localparam logic [7:0] CH_LF     = 8'h0A;
  localparam logic [7:0] CH_CR     = 8'h0D;

  function automatic logic [7:0] hexChar(input logic [3:0] nib);
    if (nib < 4'd10) return 8'h30 + {4'b0, nib};
    else             return 8'h57 + {4'b0, nib};
  endfunction

endpackage

// File: rtl/dbg_frm_dp.sv
module dbg_frm_dp
  import dbg_frm_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int ADDR_W  = $clog2(MAX_LEN),
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadWe,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  input  logic [LEN_W-1:0]  reqLen,
  input  strobe_t           stb,
  output logic [7:0]        outByte,
  output logic              lenZero,
  output logic              lastIdx,
  output logic              crPending
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  logic [7:0]       payMem [MAX_LEN];
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] idx;
  logic [7:0]       sum;
  logic             crDone;
  logic [7:0]       curByte;

  always_ff @(posedge clk) begin
    if (loadWe) payMem[loadAddr] <= loadData;
  end

  assign curByte = payMem[idx[ADDR_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenQ   <= '0;
      idx    <= '0;
      sum    <= '0;
      crDone <= 1'b0;
    end else begin
      if (stb.lenLoad) lenQ <= (reqLen > LEN_MAX) ? LEN_MAX : reqLen;
      if (stb.idxClr)      idx <= '0;
      else if (stb.idxInc) idx <= idx + LEN_W'(1);
      if (stb.sumInit)     sum <= CH_TAG;
      else if (stb.sumAdd) sum <= sum + outByte;
      if (stb.crClr)       crDone <= 1'b0;
      else if (stb.crSet)  crDone <= 1'b1;
    end
  end

  assign lenZero   = (lenQ == '0);
  assign lastIdx   = (idx == lenQ - LEN_W'(1));
  assign crPending = (curByte == CH_LF) && !crDone;

  always_comb begin
    unique case (stb.sel)
      SEL_DOLLAR: outByte = CH_DOLLAR;
      SEL_TAG:    outByte = CH_TAG;
      SEL_HI:     outByte = hexChar(curByte[7:4]);
      SEL_LO:     outByte = hexChar(curByte[3:0]);
      SEL_HASH:   outByte = CH_HASH;
      SEL_CKHI:   outByte = hexChar(sum[7:4]);
      SEL_CKLO:   outByte = hexChar(sum[3:0]);
      default:    outByte = crPending ? CH_CR : curByte;
    endcase
  end

  // R1: the read index never runs past the captured length
  a_r1_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= lenQ);

endmodule

// File: rtl/dbg_frm_ctrl.sv
module dbg_frm_ctrl
  import dbg_frm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       rawMode,
  input  logic       outReady,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       lenZero,
  input  logic       lastIdx,
  input  logic       crPending,
  output logic       outValid,
  output logic       done,
  output strobe_t    stb
);

  state_t st, stNext;
  logic   doneNext;
  logic   hs;

  assign hs = outValid && outReady;

  always_comb begin
    unique case (st)
      ST_IDLE, ST_WAIT: outValid = 1'b0;
      ST_RAW:           outValid = !lenZero;
      default:          outValid = 1'b1;
    endcase
  end

  always_comb begin
    stNext   = st;
    doneNext = 1'b0;
    stb      = '0;
    stb.sel  = SEL_RAW;
    unique case (st)
      ST_IDLE: begin
        if (startReq) begin
          stb.lenLoad = 1'b1;
          stb.idxClr  = 1'b1;
          stb.crClr   = 1'b1;
          stNext      = rawMode ? ST_RAW : ST_DOLLAR;
        end
      end
      ST_DOLLAR: begin
        stb.sel = SEL_DOLLAR;
        if (hs) stNext = ST_TAG;
      end
      ST_TAG: begin
        stb.sel = SEL_TAG;
        if (hs) begin
          stb.sumInit = 1'b1;
          stNext      = lenZero ? ST_HASH : ST_HI;
        end
      end
      ST_HI: begin
        stb.sel = SEL_HI;
        if (hs) begin
          stb.sumAdd = 1'b1;
          stNext     = ST_LO;
        end
      end
      ST_LO: begin
        stb.sel = SEL_LO;
        if (hs) begin
          stb.sumAdd = 1'b1;
          stb.idxInc = 1'b1;
          stNext     = lastIdx ? ST_HASH : ST_HI;
        end
      end
      ST_HASH: begin
        stb.sel = SEL_HASH;
        if (hs) stNext = ST_CKHI;
      end
      ST_CKHI: begin
        stb.sel = SEL_CKHI;
        if (hs) stNext = ST_CKLO;
      end
      ST_CKLO: begin
        stb.sel = SEL_CKLO;
        if (hs) stNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (rxValid) begin
          if (rxData == CH_ACK) begin
            doneNext = 1'b1;
            stNext   = ST_IDLE;
          end else begin
            stb.idxClr = 1'b1;
            stNext     = ST_DOLLAR;
          end
        end
      end
      ST_RAW: begin
        stb.sel = SEL_RAW;
        if (lenZero) begin
          doneNext = 1'b1;
          stNext   = ST_IDLE;
        end else if (hs) begin
          if (crPending) begin
            stb.crSet = 1'b1;
          end else begin
            stb.crClr  = 1'b1;
            stb.idxInc = 1'b1;
            if (lastIdx) begin
              doneNext = 1'b1;
              stNext   = ST_IDLE;
            end
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= stNext;
      done <= doneNext;
    end
  end

  // R6: a non-acknowledge byte in the wait state restarts the packet at '$'
  a_r6_nack_resend: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && rxValid && rxData != CH_ACK) |=> (st == ST_DOLLAR));

  // R10: done only follows the acknowledge wait or the raw send
  a_r10_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st) == ST_WAIT || $past(st) == ST_RAW));

endmodule

// File: rtl/dbg_pkt_framer.sv
module dbg_pkt_framer
  import dbg_frm_pkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int ADDR_W = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadWe,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  input  logic [LEN_W-1:0]  payLen,
  input  logic              rawMode,
  input  logic              startReq,
  output logic [7:0]        outData,
  output logic              outValid,
  input  logic              outReady,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  output logic              done
);

  strobe_t stb;
  logic    lenZero, lastIdx, crPending;

  dbg_frm_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .rawMode  (rawMode),
    .outReady (outReady),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .lenZero  (lenZero),
    .lastIdx  (lastIdx),
    .crPending(crPending),
    .outValid (outValid),
    .done     (done),
    .stb      (stb)
  );

  dbg_frm_dp #(.MAX_LEN(MAX_LEN)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .loadWe   (loadWe),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .reqLen   (payLen),
    .stb      (stb),
    .outByte  (outData),
    .lenZero  (lenZero),
    .lastIdx  (lastIdx),
    .crPending(crPending)
  );

  // R7: a stalled byte is held
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/dbg_pkt_framer_tb.sv
module dbg_pkt_framer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loadWe = 1'b0;
  logic [5:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic [6:0] payLen = '0;
  logic       rawMode = 1'b0;
  logic       startReq = 1'b0;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxValid = 1'b0;
  logic       done;

  int nChk = 0;
  int nErr = 0;
  int doneCnt = 0;
  int cycles = 0;
  logic [7:0] expQ[$];
  logic [7:0] payload[64];
  logic       prevDone = 1'b0;
  logic       stalled = 1'b0;
  logic [7:0] stalledByte = '0;

  always #4 clk = ~clk;

  dbg_pkt_framer u_dut (
    .clk(clk), .rst_n(rst_n), .loadWe(loadWe), .loadAddr(loadAddr),
    .loadData(loadData), .payLen(payLen), .rawMode(rawMode),
    .startReq(startReq), .outData(outData), .outValid(outValid),
    .outReady(outReady), .rxData(rxData), .rxValid(rxValid), .done(done)
  );

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h61 + 8'(n) - 8'd10;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R1 R2 R3: expected framed packet
  task automatic pushFrame(input int len);
    logic [7:0] ck = 8'h4F;
    expQ.push_back(8'h24);
    expQ.push_back(8'h4F);
    for (int i = 0; i < len; i++) begin
      expQ.push_back(hx(payload[i][7:4]));
      expQ.push_back(hx(payload[i][3:0]));
      ck = ck + hx(payload[i][7:4]) + hx(payload[i][3:0]);
    end
    expQ.push_back(8'h23);
    expQ.push_back(hx(ck[7:4]));
    expQ.push_back(hx(ck[3:0]));
  endtask

  // R9: expected raw stream
  task automatic pushRaw(input int len);
    for (int i = 0; i < len; i++) begin
      if (payload[i] == 8'h0A) expQ.push_back(8'h0D);
      expQ.push_back(payload[i]);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    logic r;
    if (rst_n) begin
      cycles++;
      if (done) doneCnt++;
      if (done && prevDone) check(1'b0, "R10 pulse width", 1, 0);
      prevDone = done;
      if (stalled) check(outValid && outData == stalledByte, "R7 hold", outData, stalledByte);
      r = ($urandom_range(0, 9) < 7);
      outReady = r;
      stalled = outValid && !r;
      stalledByte = outData;
      if (outValid && r) begin
        if (expQ.size() == 0) check(1'b0, "R1 unexpected byte", outData, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(outData == e, "R1/R2/R3/R9 byte", outData, e);
        end
      end
    end
  end

  task automatic loadBuf(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      loadWe = 1'b1; loadAddr = 6'(i); loadData = payload[i];
    end
    @(negedge clk);
    loadWe = 1'b0;
  endtask

  task automatic start(input int len, input bit raw);
    @(negedge clk);
    payLen = 7'(len); rawMode = raw; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (expQ.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && done == 1'b0, "R5 reset idle", outValid, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R5: mixed nibbles
    payload[0] = 8'h00; payload[1] = 8'hFF; payload[2] = 8'hA5; payload[3] = 8'h3C;
    loadBuf(4);
    pushFrame(4);
    start(4, 1'b0);
    drain();
    check(outValid == 1'b0, "R5 silent while waiting", outValid, 0);
    d0 = doneCnt;
    sendRx(8'h2B);
    repeat (3) @(negedge clk);
    check(doneCnt == d0 + 1, "R5 ack completes", doneCnt - d0, 1);

    // R4: zero length
    expQ.push_back(8'h24); expQ.push_back(8'h4F); expQ.push_back(8'h23);
    expQ.push_back(8'h34); expQ.push_back(8'h66);
    start(0, 1'b0);
    drain();
    sendRx(8'h2B);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4 zero frame", expQ.size(), 0);

    // R6 R8 R11: nack resend, early '+', busy start
    for (int i = 0; i < 6; i++) payload[i] = 8'(8'h41 + i * 17);
    loadBuf(6);
    pushFrame(6);
    pushFrame(6);
    d0 = doneCnt;
    start(6, 1'b0);
    repeat (5) @(negedge clk);
    sendRx(8'h2B);
    start(2, 1'b1);
    while (expQ.size() > 17) @(negedge clk);
    repeat (6) @(negedge clk);
    check(outValid == 1'b0 && doneCnt == d0, "R8 early ack ignored", doneCnt - d0, 0);
    sendRx(8'h2D);
    drain();
    check(doneCnt == d0, "R6 no done on nack", doneCnt - d0, 0);
    sendRx(8'h2B);
    repeat (3) @(negedge clk);
    check(doneCnt == d0 + 1 && expQ.size() == 0, "R6 resend then ack", doneCnt - d0, 1);

    // R9 R10: raw mode with line feeds
    payload[0] = 8'h41; payload[1] = 8'h0A; payload[2] = 8'h0A; payload[3] = 8'h0D; payload[4] = 8'h0A;
    loadBuf(5);
    pushRaw(5);
    d0 = doneCnt;
    start(5, 1'b1);
    drain();
    check(doneCnt == d0 + 1, "R10 raw done", doneCnt - d0, 1);
    sendRx(8'h2D);
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R9 no ack phase in raw", outValid, 0);

    // R3 R11: full buffer, length clamped from 100
    for (int i = 0; i < 64; i++) payload[i] = 8'($urandom_range(0, 255));
    loadBuf(64);
    pushFrame(64);
    start(100, 1'b0);
    drain();
    d0 = doneCnt;
    sendRx(8'h2B);
    repeat (3) @(negedge clk);
    check(doneCnt == d0 + 1 && expQ.size() == 0, "R11 clamp and R3 long sum", doneCnt - d0, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nChk++; nErr++;
    $display("FAIL watchdog: actual %0d expected 0", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule